// File: doc/BRIEF.md
# Dual-Channel Receive Write Checker

This block sits between a host write port and a two-channel decoder buffer. Each frame, the host writes one block of receive bytes per active channel. The block passes each accepted byte to the decoder side with a per-channel valid strobe. It counts bytes to find out when a channel's block for the frame is complete. A frame tick starts a new frame.

When only channel 0 is enabled, the block runs in single mode, and bytes addressed to channel 1 are dropped without any error. When both channels are enabled, the block switches to dual mode at the next frame tick and raises a status flag. The host may then fill the two channels in either order.

Once a channel's block is complete, more bytes for that channel in the same frame do not replace the first block. They are dropped, and a sticky error flag is raised. The host clears the flag with a write-one-to-clear strobe.

Top module: `rx_dual_write_chk`

## Requirements
- R1: `dual_mode_o` changes only one cycle after a cycle with `frame_tick_i` high. It then takes the value `ch0_en_i & ch1_en_i` sampled in that tick cycle, so dual mode begins within one frame of enabling channel 1.
- R2: A byte is accepted when `wr_valid_i` is high and the selected channel is open. `wr_ch_i` = 0 selects channel 0 and 1 selects channel 1. Channel 0 is open while `ch0_en_i` = 1, and channel 1 is open while `dual_mode_o` = 1. On the next cycle, `dec_valid_o[c]` is 1 and `dec_data_o` carries the byte.
- R3: Within one frame, the two channels may be written in either order, channel 0 first or channel 1 first, without setting `dup_err_o`.
- R4: A channel's block is complete once `BLOCK_BYTES` (default 80) bytes have been accepted for it in the current frame. The channel is then marked as written for that frame.
- R5: A byte for a channel already marked written in the current frame is discarded: `dec_valid_o` for that channel stays 0. `dup_err_o` is 1 on the following cycle. The first block stays as it was delivered.
- R6: A frame tick clears both written markers and any partial byte counts. A byte written in the same cycle as the tick counts as the first byte of the new frame.
- R7: `dup_err_o` stays 1 until a cycle with `err_clr_i` = 1 and no new duplicate. If a duplicate and a clear arrive in the same cycle, the flag stays set.
- R8: Bytes for channel 1 while `dual_mode_o` = 0, and bytes for channel 0 while `ch0_en_i` = 0, produce no valid strobe and do not set `dup_err_o`.
- R9: After reset, all outputs are 0, and at most one bit of `dec_valid_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_tick_i | input | 1 | One-cycle frame boundary pulse |
| ch0_en_i | input | 1 | Channel 0 enable |
| ch1_en_i | input | 1 | Channel 1 enable |
| wr_valid_i | input | 1 | Host byte write strobe |
| wr_ch_i | input | 1 | Target channel of the write (0 or 1) |
| wr_data_i | input | DATA_W | Written byte |
| err_clr_i | input | 1 | Write-one-to-clear for the error flag |
| dual_mode_o | output | 1 | Two writes per frame expected |
| dec_valid_o | output | 2 | Per-channel byte valid toward decoder (bit c = channel c) |
| dec_data_o | output | DATA_W | Forwarded byte |
| dup_err_o | output | 1 | Sticky duplicate-write error |

## Verification
Directed sequences cover the following cases:
- Channel 1 filled before channel 0 in one frame, then channel 0 before channel 1 in the next, which shows that order does not matter.
- A single extra byte after a complete block, which shows the difference between a discard and an overwrite.
- A tick that coincides with a write, and a partial block cut off by a tick, which shows whether counts restart at the frame boundary.
- Set and clear of the error in the same cycle.
- Channel 1 traffic in single mode, which shows an ignore apart from an error.

Seeded random traffic then mixes ticks, enable changes, clears and writes to either channel against a bench-side frame model.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic {
    CH_ZERO = 1'b0,
    CH_ONE  = 1'b1
  } ch_sel_e;
endpackage

// File: rtl/rxw_mode_ctrl.sv
module rxw_mode_ctrl
  import rxw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_tick_i,
  input  logic              ch0_en_i,
  input  logic              ch1_en_i,
  output logic              dual_o,
  output logic [NUM_CH-1:0] ch_open_o
);
  logic dual_q;

  // mode only moves at frame boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           dual_q <= 1'b0;
    else if (frame_tick_i) dual_q <= ch0_en_i & ch1_en_i;
  end

  assign dual_o       = dual_q;
  assign ch_open_o[0] = ch0_en_i;
  assign ch_open_o[1] = dual_q;

  a_r1_mode_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dual_q) |-> $past(frame_tick_i));

  a_r1_mode_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick_i |=> (dual_q == $past(ch0_en_i & ch1_en_i)));
endmodule

// File: rtl/rxw_chan_track.sv
module rxw_chan_track #(
  parameter int unsigned BLOCK_BYTES = 80,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              fwd_valid_o,
  output logic [DATA_W-1:0] fwd_data_o,
  output logic              done_o,
  output logic              dup_o
);
  localparam int unsigned CNT_W = $clog2(BLOCK_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_eff, cnt_d;
  logic              done_q, done_eff, done_d;
  logic              take, last;
  logic              fwd_valid_q;
  logic [DATA_W-1:0] fwd_data_q;

  // a write coinciding with the tick belongs to the new frame
  assign done_eff = done_q & ~frame_tick_i;
  assign cnt_eff  = frame_tick_i ? '0 : cnt_q;
  assign take     = wr_i & ~done_eff;
  assign dup_o    = wr_i & done_eff;
  assign last     = (cnt_eff == LAST_IDX);

  always_comb begin
    cnt_d  = cnt_eff;
    done_d = done_eff;
    if (take) begin
      if (last) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d  = cnt_eff + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      done_q      <= 1'b0;
      fwd_valid_q <= 1'b0;
      fwd_data_q  <= '0;
    end else begin
      cnt_q       <= cnt_d;
      done_q      <= done_d;
      fwd_valid_q <= take;
      if (take) fwd_data_q <= data_i;
    end
  end

  assign fwd_valid_o = fwd_valid_q;
  assign fwd_data_o  = fwd_data_q;
  assign done_o      = done_q;

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(BLOCK_BYTES));

  a_r5_no_fwd_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !frame_tick_i && wr_i) |=> !fwd_valid_o);

  a_r6_tick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_tick_i && !wr_i) |=> !done_o);
endmodule

// File: rtl/rxw_err_flag.sv
module rxw_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (set_i)  err_q <= 1'b1;
    else if (clr_i)  err_q <= 1'b0;
  end

  assign err_o = err_q;

  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_o);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
endmodule

// File: rtl/rx_dual_write_chk.sv
module rx_dual_write_chk
  import rxw_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 80,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_tick_i,
  input  logic              ch0_en_i,
  input  logic              ch1_en_i,
  input  logic              wr_valid_i,
  input  logic              wr_ch_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              err_clr_i,
  output logic              dual_mode_o,
  output logic [1:0]        dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dup_err_o
);
  logic [NUM_CH-1:0] ch_open, wr_hit, fwd_valid, done, dup;
  logic [DATA_W-1:0] fwd_data [NUM_CH];
  logic              dup_any;

  rxw_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_tick_i(frame_tick_i),
    .ch0_en_i    (ch0_en_i),
    .ch1_en_i    (ch1_en_i),
    .dual_o      (dual_mode_o),
    .ch_open_o   (ch_open)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_hit[c] = wr_valid_i & ch_open[c] & (wr_ch_i == ch_sel_e'(c));

    rxw_chan_track #(
      .BLOCK_BYTES(BLOCK_BYTES),
      .DATA_W     (DATA_W)
    ) u_track (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .frame_tick_i(frame_tick_i),
      .wr_i        (wr_hit[c]),
      .data_i      (wr_data_i),
      .fwd_valid_o (fwd_valid[c]),
      .fwd_data_o  (fwd_data[c]),
      .done_o      (done[c]),
      .dup_o       (dup[c])
    );
  end

  assign dup_any = |dup;

  rxw_err_flag u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (dup_any),
    .clr_i (err_clr_i),
    .err_o (dup_err_o)
  );

  assign dec_valid_o = fwd_valid;
  assign dec_data_o  = fwd_valid[1] ? fwd_data[1] : fwd_data[0];

  a_r9_onehot_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dec_valid_o));

  a_r8_ch1_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ch_i && !dual_mode_o) |=> !dec_valid_o[1]);

  a_r8_no_err_when_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ch_i && !dual_mode_o && !dup_err_o) |=> !dup_err_o);

  a_r3_r5_written_blocks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done[1] && wr_valid_i && wr_ch_i && !frame_tick_i) |=> (!dec_valid_o[1] && dup_err_o));
endmodule

// File: tb/rx_dual_write_chk_test.sv
module rx_dual_write_chk_test;
  localparam int BB = 80;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0, en0 = 1'b0, en1 = 1'b0, wv = 1'b0, wch = 1'b0, clr = 1'b0;
  logic [7:0] wd = '0;
  logic       dual_o, err_o;
  logic [1:0] vld_o;
  logic [7:0] data_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // bench frame model
  bit      m_dual = 0, m_err = 0;
  bit      m_done [2] = '{0, 0};
  int      m_cnt  [2] = '{0, 0};

  always #4 clk = ~clk;

  rx_dual_write_chk #(.BLOCK_BYTES(BB), .DATA_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_tick_i(tick), .ch0_en_i(en0), .ch1_en_i(en1),
    .wr_valid_i(wv), .wr_ch_i(wch), .wr_data_i(wd), .err_clr_i(clr),
    .dual_mode_o(dual_o), .dec_valid_o(vld_o), .dec_data_o(data_o), .dup_err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic bit ch_open(input bit ch);
    return ch ? m_dual : en0;
  endfunction

  task automatic step(input bit t, input bit v, input bit c, input logic [7:0] d, input bit cl,
                      input string req);
    bit [1:0] exp_v;
    bit       dup;
    @(negedge clk);
    tick = t; wv = v; wch = c; wd = d; clr = cl;
    exp_v = '0; dup = 0;
    for (int k = 0; k < 2; k++) begin
      if (t) begin m_done[k] = 0; m_cnt[k] = 0; end
    end
    if (v && ch_open(c)) begin
      if (m_done[c]) dup = 1;
      else begin
        exp_v[c] = 1'b1;
        m_cnt[c]++;
        if (m_cnt[c] == BB) begin m_cnt[c] = 0; m_done[c] = 1; end
      end
    end
    if (t) m_dual = en0 & en1;
    if (dup) m_err = 1; else if (cl) m_err = 0;
    @(posedge clk); #1;
    check({req, " R1 dual_mode"}, dual_o, m_dual);
    check({req, " R2/R9 dec_valid"}, vld_o, exp_v);
    if (exp_v != 0) check({req, " R2 dec_data"}, data_o, d);
    check({req, " R5/R7 dup_err"}, err_o, m_err);
    tick = 0; wv = 0; clr = 0;
  endtask

  task automatic block(input bit c, input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 1, c, 8'(i * 7 + c), 0, req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #13;
    check("R9 reset dual", dual_o, 0);
    check("R9 reset valid", vld_o, 0);
    check("R9 reset err", err_o, 0);
    @(negedge clk); rst_ni = 1'b1;

    // R8: single mode, ch1 writes ignored without error
    en0 = 1; en1 = 0;
    step(1, 0, 0, 0, 0, "R1 tick single");
    block(1, 5, "R8 ch1 in single mode");
    block(0, 3, "R2 ch0 single");
    en0 = 0;
    block(0, 2, "R8 ch0 disabled");
    en0 = 1; en1 = 1;
    block(1, 2, "R1 before tick");
    step(1, 0, 0, 0, 0, "R1 enter dual");
    // R3: ch1 first then ch0
    block(1, BB, "R3 ch1 first");
    block(0, BB, "R3 ch0 second");
    check("R3 no error after both orders", err_o, 0);
    // R5 duplicate
    step(0, 1, 0, 8'hAA, 0, "R5 dup ch0");
    check("R5 dup sets error", err_o, 1);
    step(0, 0, 0, 0, 0, "R7 sticky");
    step(0, 1, 1, 8'hBB, 1, "R7 set beats clear");
    step(0, 0, 0, 0, 1, "R7 clear");
    // R6 tick with write, ch0 then ch1 order
    step(1, 1, 0, 8'h11, 0, "R6 write on tick");
    block(0, BB - 1, "R4 ch0 first");
    block(1, BB, "R3 ch1 second");
    step(0, 1, 1, 8'h22, 0, "R5 dup ch1");
    step(0, 0, 0, 0, 1, "R7 clear");
    // R6 partial block then tick
    step(1, 0, 0, 0, 0, "R6 tick");
    block(0, 30, "R6 partial");
    step(1, 0, 0, 0, 0, "R6 tick partial");
    block(0, BB, "R4 full after partial");
    step(0, 1, 0, 8'h33, 0, "R5 after full");
    step(0, 0, 0, 0, 1, "R7 clear");
    en1 = 0;
    step(1, 0, 0, 0, 0, "R1 leave dual");
    block(1, 3, "R8 ch1 after leave");

    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 399) == 0) en1 = ~en1;
      if ($urandom_range(0, 999) == 0) en0 = ~en0;
      step($urandom_range(0, 219) == 0, $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)),
           8'($urandom), $urandom_range(0, 59) == 0, "R2 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule